// File: doc/BRIEF.md
# Serial Nonvolatile Memory Slave Command Engine

This block is the digital core of a small serial memory slave. It holds 128 words of 8 bits in a register array and talks to a host over four wires: an active-low select, a serial clock, a data input and a data output with a separate drive enable. The drive enable lets the pad be placed in high impedance. The serial pins are synchronized into the system clock domain. Every serial clock edge is then detected there, so the serial clock must run well below the system clock: each serial clock phase lasts at least four system clocks.

Each frame opens with an 8-bit address field and then an 8-bit command field. Both fields go least significant bit first. Read and program frames add an 8-bit data field. A program or erase-all starts a self-timed busy period whose length is a parameter counted in system clocks. While that period runs, only a status query is honoured. A protect latch gates program and erase-all. Reset sets the latch to protected, and two commands set or clear it. The storage keeps its contents through reset, in the same way a nonvolatile array would.

The serial pins carry no valid/ready handshake. The serial clock itself paces every bit, and the host reads readiness through the status command.

Top module: `serial_nvm_slave`

## Requirements
- R1: A frame has three fields, all least significant bit first. Serial clocks 1 to 8 carry the address field: address bits 0..6 on clocks 1..7, and clock 8 carries a padding 0. Clocks 9 to 16 carry the command byte, and clocks 17 to 24 carry data. The command byte values are: read 0x02, program 0x06, erase-all 0x0C, status 0x0D, unlock 0x09 and lock 0x0B.
- R2: A read frame returns the addressed word on `sdo` with `sdo_en` high. Bit 0 is driven after the falling serial edge that begins clock 17, and each later falling edge up to the one that begins clock 24 drives the next bit.
- R3: When the block is unlocked and ready, a program frame writes its data byte to the addressed word once the 24th rising serial edge has been seen.
- R4: When the block is unlocked and ready, an erase-all command clears every word to 0x00 after the 16th rising serial edge.
- R5: The status command drives `sdo` = 0 while a program or erase is running and `sdo` = 1 otherwise. It keeps driving, following the busy state, until select is raised.
- R6: A started program or erase keeps the block busy for exactly PROG_CYCLES system clocks.
- R7: While busy, read, program, erase-all, unlock, lock and any other command are ignored. Only the status command is honoured.
- R8: After reset and after a lock command, program and erase-all are ignored until an unlock command is accepted. Reset does not alter stored words.
- R9: `sdo_en` is low except while read data or status is being driven. It returns low within SYNC_STAGES+1 system clocks after select goes high.
- R10: A command byte not listed in R1 is ignored. Nothing is driven and nothing is stored.
- R11: Raising select before a frame completes discards the partial frame without side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, forces the protected state |
| sel_n | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock; idles high |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| sdo | output | 1 | Serial data out, changes after falling sclk |
| sdo_en | output | 1 | Drive enable for sdo; low means high impedance |

## Verification
The bench builds the block with its default 7-bit address and 8-bit word, so all 128 words are swept: each is programmed with an arithmetic pattern and then read back. PROG_CYCLES is cut to 400 system clocks. At that length a status frame, or a rejected read or program, fits inside a single busy period, so the ready/busy reporting and the rejection of commands while busy can be exercised directly. Serial phases of five system clocks sit close to the minimum the synchronizers allow.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [7:0] OP_READ   = 8'h02;
  localparam logic [7:0] OP_WRITE  = 8'h06;
  localparam logic [7:0] OP_ERASE  = 8'h0C;
  localparam logic [7:0] OP_STATUS = 8'h0D;
  localparam logic [7:0] OP_UNLOCK = 8'h09;
  localparam logic [7:0] OP_LOCK   = 8'h0B;

  typedef enum logic [1:0] {
    OUT_IDLE,
    OUT_READ,
    OUT_STAT
  } out_mode_e;
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= {STAGES{INIT}};
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/nvm_frame_rx.sv
module nvm_frame_rx #(
  parameter int ADDR_W = 7,
  parameter int FLD    = 8,
  localparam int CNT_W = $clog2(3*FLD+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              active,
  output logic              fall,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr,
  output logic [FLD-1:0]    cmd,
  output logic [FLD-1:0]    data,
  output logic              hdr_done,
  output logic              frame_done
);
  localparam logic [CNT_W-1:0] END_ADDR = CNT_W'(FLD);
  localparam logic [CNT_W-1:0] END_CMD  = CNT_W'(2*FLD);
  localparam logic [CNT_W-1:0] END_ALL  = CNT_W'(3*FLD);

  logic           sclk_q;
  logic           rise;
  logic [FLD-1:0] addr_sr;

  assign active = !sel_n;
  assign rise   = active && sclk && !sclk_q;
  assign fall   = active && !sclk && sclk_q;
  assign addr   = addr_sr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      cnt        <= '0;
      addr_sr    <= '0;
      cmd        <= '0;
      data       <= '0;
      hdr_done   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      hdr_done   <= 1'b0;
      frame_done <= 1'b0;
      if (!active) begin
        cnt <= '0;
      end else if (rise && cnt < END_ALL) begin
        cnt <= cnt + 1'b1;
        if (cnt < END_ADDR)     addr_sr <= {sdi, addr_sr[FLD-1:1]};
        else if (cnt < END_CMD) cmd     <= {sdi, cmd[FLD-1:1]};
        else                    data    <= {sdi, data[FLD-1:1]};
        hdr_done   <= (cnt == END_CMD - 1'b1);
        frame_done <= (cnt == END_ALL - 1'b1);
      end
    end
  end
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int CYCLES = 100000,
  localparam int CW    = $clog2(CYCLES+1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         left <= '0;
    else if (start)     left <= CW'(CYCLES);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  import nvm_pkg::*;

  localparam int FLD   = DATA_W;
  localparam int CNT_W = $clog2(3*FLD+1);
  localparam logic [CNT_W-1:0] END_ALL = CNT_W'(3*FLD);

  logic [2:0]        sync_q;
  logic              rx_active, rx_fall, hdr_done, frame_done;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr;
  logic [FLD-1:0]    cmd, data;
  logic              busy, ready, wen, start, erase_go, write_go;
  logic [DATA_W-1:0] rdata, rd_sr;
  out_mode_e         mode;

  nvm_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sel_n, sclk, sdi}), .q(sync_q)
  );

  nvm_frame_rx #(.ADDR_W(ADDR_W), .FLD(FLD)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sel_n(sync_q[2]), .sclk(sync_q[1]), .sdi(sync_q[0]),
    .active(rx_active), .fall(rx_fall), .cnt(bit_cnt),
    .addr(addr), .cmd(cmd), .data(data),
    .hdr_done(hdr_done), .frame_done(frame_done)
  );

  nvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
  );

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(write_go), .waddr(addr), .wdata(data),
    .clr(erase_go), .raddr(addr), .rdata(rdata)
  );

  assign ready    = !busy;
  assign erase_go = hdr_done   && ready && wen && (cmd == OP_ERASE);
  assign write_go = frame_done && ready && wen && (cmd == OP_WRITE);
  assign start    = erase_go || write_go;

  // protect latch: reset leaves the array locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
    end else if (hdr_done && ready) begin
      if (cmd == OP_UNLOCK)    wen <= 1'b1;
      else if (cmd == OP_LOCK) wen <= 1'b0;
    end
  end

  // output driver
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= OUT_IDLE;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
      rd_sr  <= '0;
    end else if (!rx_active) begin
      mode   <= OUT_IDLE;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (hdr_done) begin
      if (cmd == OP_STATUS) begin
        mode   <= OUT_STAT;
        sdo_en <= 1'b1;
        sdo    <= ready;
      end else if (cmd == OP_READ && ready) begin
        mode  <= OUT_READ;
        rd_sr <= rdata;
      end
    end else begin
      case (mode)
        OUT_STAT: sdo <= ready;
        OUT_READ: if (rx_fall) begin
          if (bit_cnt < END_ALL) begin
            sdo_en <= 1'b1;
            sdo    <= rd_sr[0];
            rd_sr  <= rd_sr >> 1;
          end else begin
            sdo_en <= 1'b0;
            mode   <= OUT_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serial_nvm_slave_chk.sv
module serial_nvm_slave_chk #(
  parameter int PROG_CYCLES = 100000,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(PROG_CYCLES+2)
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic sdo,
  input logic sdo_en,
  input logic busy,
  input logic start,
  input logic wen,
  input logic st_mode
);
  logic [BW-1:0] busy_len;
  logic [3:0]    sel_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_len <= '0;
    else if (start) busy_len <= '0;
    else if (busy)  busy_len <= busy_len + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sel_hi <= '0;
    else if (!sel_n)        sel_hi <= '0;
    else if (sel_hi != 4'hF) sel_hi <= sel_hi + 1'b1;
  end

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == BW'(PROG_CYCLES)));

  a_r7_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  a_r8_locked_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !wen);

  a_r9_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_hi) > SYNC_STAGES) |-> !sdo_en);

  a_r5_status_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mode && sdo_en && $past(st_mode) && $past(sdo_en)) |-> (sdo == !$past(busy)));
endmodule

bind serial_nvm_slave serial_nvm_slave_chk #(
  .PROG_CYCLES(PROG_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sdo(sdo), .sdo_en(sdo_en),
  .busy(busy), .start(start), .wen(wen), .st_mode(mode == nvm_pkg::OUT_STAT)
);

// File: tb/serial_nvm_slave_tb.sv
module serial_nvm_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 400;
  localparam int HALF       = 5;
  localparam int WATCHDOG   = 199000;

  localparam logic [7:0] C_READ = 8'h02, C_WRITE = 8'h06, C_ERASE = 8'h0C;
  localparam logic [7:0] C_STAT = 8'h0D, C_UNLK  = 8'h09, C_LOCK  = 8'h0B;

  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo, sdo_en;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_nvm_slave #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits serial clocks; keep=1 leaves select low afterwards
  task automatic frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] d,
                       input int nbits, input bit keep,
                       output logic [7:0] rd, output bit en_any, output bit en_all);
    rd = '0; en_any = 1'b0; en_all = 1'b1;
    @(negedge clk);
    sel_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdi  = (i < 8) ? a[i] : (i < 16) ? c[i-8] : d[i-16];
      idle(HALF);
      en_any |= sdo_en;
      if (i >= 16) begin
        rd[i-16] = sdo;
        en_all &= sdo_en;
      end
      sclk = 1'b1;
      idle(HALF);
    end
    if (!keep) begin
      sel_n = 1'b1;
      idle(2*HALF);
    end
  endtask

  task automatic rd_word(input int a, output logic [7:0] v, output bit en_all);
    bit any;
    frame(8'(a), C_READ, 8'h00, 24, 1'b0, v, any, en_all);
  endtask

  task automatic short_cmd(input logic [7:0] c);
    logic [7:0] r; bit x, y;
    frame(8'h00, c, 8'h00, 16, 1'b0, r, x, y);
  endtask

  task automatic wr_word(input int a, input logic [7:0] v, output bit en_any);
    logic [7:0] r; bit y;
    frame(8'(a), C_WRITE, v, 24, 1'b0, r, en_any, y);
  endtask

  // status frame left selected; returns driven bit and enable
  task automatic status_open(output logic s, output logic e);
    logic [7:0] r; bit x, y;
    frame(8'h00, C_STAT, 8'h00, 16, 1'b1, r, x, y);
    idle(4);
    s = sdo; e = sdo_en;
  endtask

  task automatic deselect();
    sel_n = 1'b1;
    idle(2*HALF);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v; bit ea, en; logic s, e;

    idle(5);
    check(sdo_en == 1'b0, "R9 reset sdo_en", sdo_en, 0);
    rst_n = 1'b1;
    idle(5);

    // R8: locked after reset, a program must not start a busy period
    wr_word(3, 8'h5A, ea);
    status_open(s, e);
    check(s == 1'b1 && e == 1'b1, "R8 locked program starts nothing", {e, s}, 3);
    deselect();
    check(sdo_en == 1'b0, "R9 released after status", sdo_en, 0);

    // R4/R5: erase, status low while busy, stays driven and turns high
    short_cmd(C_UNLK);
    short_cmd(C_ERASE);
    status_open(s, e);
    check(s == 1'b0 && e == 1'b1, "R5 busy during erase", {e, s}, 2);
    idle(PROG);
    check(sdo == 1'b1 && sdo_en == 1'b1, "R5 ready and still driven", {sdo_en, sdo}, 3);
    deselect();
    rd_word(0, v, en);
    check(v == 8'h00 && en, "R4 erase addr 0", v, 0);
    rd_word(127, v, en);
    check(v == 8'h00 && en, "R4 erase addr 127", v, 0);

    // R1/R2/R3: full sweep
    for (int a = 0; a < 128; a++) begin
      wr_word(a, pat(a), ea);
      if (a == 0) check(ea == 1'b0, "R9 no drive in program frame", ea, 0);
      idle(PROG + 20);
    end
    for (int a = 0; a < 128; a++) begin
      rd_word(a, v, en);
      check(v == pat(a) && en, "R2 R3 readback", v, pat(a));
    end

    // R7: program during busy is ignored
    wr_word(10, 8'h11, ea);
    wr_word(11, 8'hEE, ea);
    idle(PROG);
    rd_word(10, v, en);
    check(v == 8'h11, "R3 addr 10 programmed", v, 8'h11);
    rd_word(11, v, en);
    check(v == pat(11), "R7 program while busy ignored", v, pat(11));

    // R7: read during busy is ignored
    wr_word(12, 8'h22, ea);
    rd_word(12, v, en);
    check(en == 1'b0, "R7 read while busy ignored", en, 0);
    idle(PROG);

    // R7: lock while busy ignored, so a later program still lands
    wr_word(13, 8'h33, ea);
    short_cmd(C_LOCK);
    idle(PROG);
    wr_word(14, 8'h44, ea);
    idle(PROG + 20);
    rd_word(14, v, en);
    check(v == 8'h44, "R7 lock while busy ignored", v, 8'h44);

    // R10: unlisted commands
    frame(8'd20, 8'h0E, 8'h99, 24, 1'b0, v, ea, en);
    check(ea == 1'b0, "R10 unlisted no drive", ea, 0);
    frame(8'd20, 8'h12, 8'h99, 24, 1'b0, v, ea, en);
    check(ea == 1'b0, "R10 upper bits set no drive", ea, 0);
    frame(8'd20, 8'h16, 8'h99, 24, 1'b0, v, ea, en);
    idle(PROG + 20);
    rd_word(20, v, en);
    check(v == pat(20), "R10 unlisted stores nothing", v, pat(20));

    // R11: partial program frame
    frame(8'd30, C_WRITE, 8'h77, 20, 1'b0, v, ea, en);
    idle(PROG + 20);
    rd_word(30, v, en);
    check(v == pat(30), "R11 partial frame discarded", v, pat(30));

    // R8: lock blocks program and erase
    short_cmd(C_LOCK);
    wr_word(40, 8'h00, ea);
    short_cmd(C_ERASE);
    idle(PROG + 20);
    rd_word(40, v, en);
    check(v == pat(40), "R8 lock blocks program", v, pat(40));
    rd_word(0, v, en);
    check(v == pat(0), "R8 lock blocks erase", v, pat(0));

    // R8: reset relocks and keeps contents
    short_cmd(C_UNLK);
    idle(2); rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(3);
    wr_word(50, 8'h00, ea);
    idle(PROG + 20);
    rd_word(50, v, en);
    check(v == pat(50), "R8 reset relocks and retains", v, pat(50));
    check(sdo_en == 1'b0, "R9 idle after read", sdo_en, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule